// File: doc/BRIEF.md
# IDE Chip-Select and Strobe Generator

This block is the glue between an 8-bit processor bus with a phi2 clock phase and a 40-pin IDE drive. It watches a small window inside the processor's I/O page and drives three active-low selects: one for each IDE register bank (the bank at the 1Fx offsets and the bank at the 3Fx offsets) and one for an external high-byte data latch. While any of the three is decoded, it pulls an enable output low so that the on-board peripheral chip, which would otherwise answer across the whole I/O page, stays silent.

The block turns the processor's phi2 and R/W into the edge-latched read and write strobes that an IDE drive expects. A drive latches write data on the rising edge of the write strobe, which happens when phi2 ends. The read strobe is low while phi2 is high, so the drive puts its data on the bus during that phase. Strobes are produced only for the two IDE banks. The high-byte latch address never strobes the drive. The three low address bits are captured when phi2 rises and are held on the IDE register address lines. The active-low block reset is also passed to the drive's reset line.

Everything runs from a fast system clock `clk`. The inputs `phi2`, `cpu_rw`, `cpu_addr` and `io_page_n` are sampled as synchronous signals of that clock.

Top module: `ide_bus_glue`

## Requirements
- R1: When `io_page_n` is 1, or `cpu_addr[7]` is 0, or `cpu_addr[4]` is 0, or `cpu_addr[3]` is 1, the outputs `ide_cs1_n`, `ide_cs3_n` and `hi_latch_n` are all 1 and `periph_en` is 1.
- R2: Inside the window, `cpu_addr[6:5]` selects the output. 00 asserts none. 01 drives `hi_latch_n` low. 10 drives `ide_cs1_n` low. 11 drives `ide_cs3_n` low. Only the selected output is low.
- R3: `periph_en` is 0 exactly when one of `ide_cs1_n`, `ide_cs3_n` or `hi_latch_n` is 0.
- R4: `ide_cs1_n` and `ide_cs3_n` are never 0 together.
- R5: `ide_da` takes `cpu_addr[2:0]` at the first `clk` edge that samples `phi2` high after it was sampled low. At every other edge it keeps its value. Reset clears it to 0.
- R6: `ide_iow_n` is 0 exactly when reset is released, `phi2` is high now and was high at the last `clk` edge, `cpu_rw` is 0, and one of the IDE banks is selected.
- R7: `ide_ior_n` is 0 under the same conditions, except that `cpu_rw` is 1.
- R8: `ide_ior_n` and `ide_iow_n` are never 0 together.
- R9: While `hi_latch_n` is 0, both strobes and both IDE bank selects are 1.
- R10: `ide_rst_n` follows `rst_n`. While in reset, both strobes are 1 and `ide_da` is 0.
- R11: Between a rise of `phi2` and the next `clk` edge, both strobes stay 1, so `ide_da` is updated before any strobe falls. A `phi2` that is already high when reset is released loads nothing until it has gone low and high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| phi2 | input | 1 | Processor bus phase, high during the data phase |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 8 | Low byte of the processor address |
| io_page_n | input | 1 | Low while the I/O page is addressed |
| ide_cs1_n | output | 1 | IDE register bank 1 select, active low |
| ide_cs3_n | output | 1 | IDE register bank 3 select, active low |
| hi_latch_n | output | 1 | High-byte latch select, active low |
| periph_en | output | 1 | Peripheral chip enable, low while the window is decoded |
| ide_da | output | 3 | IDE register address |
| ide_ior_n | output | 1 | IDE read strobe, active low |
| ide_iow_n | output | 1 | IDE write strobe, active low |
| ide_rst_n | output | 1 | IDE drive reset, active low |

## Verification
Every one of the 256 address values is applied with the page select at both levels and with both read and write. Each combination runs through a low-high-high-low phi2 cycle, so the window gating, the four slot codes and the strobe direction are each told apart from the others. In one run the address changes while phi2 is high, which separates a capture on the phi2 rise from transparent following. Another run releases reset while phi2 is high, which separates "load on a fresh rise" from "load whenever phi2 is high". A check taken in the gap between the phi2 rise and the next clock edge separates strobes that wait for a settled address from strobes that follow phi2 at once.

// File: rtl/ide_glue_pkg.sv
package ide_glue_pkg;
  // Meaning of the two slot bits inside the decode window.
  typedef enum logic [1:0] {
    SLOT_NONE   = 2'd0,
    SLOT_HIBYTE = 2'd1,
    SLOT_SET1   = 2'd2,
    SLOT_SET3   = 2'd3
  } slot_e;

  localparam int NUM_SLOTS = 4;
endpackage

// File: rtl/ide_win_decode.sv
module ide_win_decode
  import ide_glue_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int HI_BIT   = 7,
  parameter int MID_BIT  = 4,
  parameter int LO_BIT   = 3,
  parameter int SLOT_LSB = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_page_n,
  output logic              cs1_n,
  output logic              cs3_n,
  output logic              hi_n,
  output logic              periph_en,
  output logic              dev_sel
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);

  logic              in_window;
  slot_e             slot;
  logic [NUM_SLOTS-1:0] slot_hit;

  assign in_window = !io_page_n && addr[HI_BIT] && addr[MID_BIT] && !addr[LO_BIT];
  assign slot      = slot_e'(addr[SLOT_LSB +: SLOT_W]);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slot_hit[s] = in_window && (slot == slot_e'(s));
  end

  assign hi_n      = !slot_hit[SLOT_HIBYTE];
  assign cs1_n     = !slot_hit[SLOT_SET1];
  assign cs3_n     = !slot_hit[SLOT_SET3];
  assign dev_sel   = slot_hit[SLOT_SET1] | slot_hit[SLOT_SET3];
  assign periph_en = !(slot_hit[SLOT_HIBYTE] | dev_sel);
endmodule

// File: rtl/ide_addr_hold.sv
module ide_addr_hold #(
  parameter int DA_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            phi2,
  input  logic [DA_W-1:0] addr_lo,
  output logic [DA_W-1:0] da,
  output logic            armed
);
  logic phi2_q;

  // phi2_q comes out of reset high, so a phase that is already running loads nothing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi2_q <= 1'b1;
      da     <= '0;
    end else begin
      phi2_q <= phi2;
      if (phi2 && !phi2_q) da <= addr_lo;
    end
  end

  // Strobes may assert only after the edge that captured the address.
  assign armed = rst_n && phi2 && phi2_q;
endmodule

// File: rtl/ide_strobe_gen.sv
module ide_strobe_gen (
  input  logic armed,
  input  logic rw,
  input  logic dev_sel,
  output logic ior_n,
  output logic iow_n
);
  logic go;

  assign go    = armed && dev_sel;
  assign ior_n = !(go && rw);
  assign iow_n = !(go && !rw);
endmodule

// File: rtl/ide_bus_glue.sv
module ide_bus_glue #(
  parameter int ADDR_W = 8,
  parameter int DA_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic              cpu_rw,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              io_page_n,
  output logic              ide_cs1_n,
  output logic              ide_cs3_n,
  output logic              hi_latch_n,
  output logic              periph_en,
  output logic [DA_W-1:0]   ide_da,
  output logic              ide_ior_n,
  output logic              ide_iow_n,
  output logic              ide_rst_n
);
  logic dev_sel;
  logic armed;

  ide_win_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr      (cpu_addr),
    .io_page_n (io_page_n),
    .cs1_n     (ide_cs1_n),
    .cs3_n     (ide_cs3_n),
    .hi_n      (hi_latch_n),
    .periph_en (periph_en),
    .dev_sel   (dev_sel)
  );

  ide_addr_hold #(.DA_W(DA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .phi2    (phi2),
    .addr_lo (cpu_addr[DA_W-1:0]),
    .da      (ide_da),
    .armed   (armed)
  );

  ide_strobe_gen u_stb (
    .armed   (armed),
    .rw      (cpu_rw),
    .dev_sel (dev_sel),
    .ior_n   (ide_ior_n),
    .iow_n   (ide_iow_n)
  );

  assign ide_rst_n = rst_n;
endmodule

// File: rtl/ide_bus_glue_chk.sv
module ide_bus_glue_chk #(
  parameter int ADDR_W = 8,
  parameter int DA_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              phi2,
  input logic              cpu_rw,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              ide_cs1_n,
  input logic              ide_cs3_n,
  input logic              hi_latch_n,
  input logic              periph_en,
  input logic [DA_W-1:0]   ide_da,
  input logic              ide_ior_n,
  input logic              ide_iow_n
);
  p_banks_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_cs1_n && !ide_cs3_n));

  p_strobes_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_ior_n && !ide_iow_n));

  p_periph_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_en |-> (!ide_cs1_n || !ide_cs3_n || !hi_latch_n));

  p_hibyte_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_latch_n |-> (ide_ior_n && ide_iow_n && ide_cs1_n && ide_cs3_n));

  p_write_needs_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ide_iow_n |-> (phi2 && !cpu_rw && (!ide_cs1_n || !ide_cs3_n)));

  p_read_needs_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ide_ior_n |-> (phi2 && cpu_rw && (!ide_cs1_n || !ide_cs3_n)));

  p_da_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(phi2)) |=> (ide_da == $past(cpu_addr[DA_W-1:0])));

  p_da_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$rose(phi2)) |=> $stable(ide_da));

  p_no_early_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(phi2)) |-> (ide_ior_n && ide_iow_n));
endmodule

bind ide_bus_glue ide_bus_glue_chk #(.ADDR_W(ADDR_W), .DA_W(DA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phi2       (phi2),
  .cpu_rw     (cpu_rw),
  .cpu_addr   (cpu_addr),
  .ide_cs1_n  (ide_cs1_n),
  .ide_cs3_n  (ide_cs3_n),
  .hi_latch_n (hi_latch_n),
  .periph_en  (periph_en),
  .ide_da     (ide_da),
  .ide_ior_n  (ide_ior_n),
  .ide_iow_n  (ide_iow_n)
);

// File: tb/test_ide_bus_glue.sv
module test_ide_bus_glue;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phi2 = 1'b0;
  logic       cpu_rw = 1'b1;
  logic [7:0] cpu_addr = '0;
  logic       io_page_n = 1'b1;
  logic       ide_cs1_n, ide_cs3_n, hi_latch_n, periph_en;
  logic [2:0] ide_da;
  logic       ide_ior_n, ide_iow_n, ide_rst_n;

  int checks = 0;
  int errors = 0;

  // Reference state
  logic       m_prev = 1'b1;
  logic [2:0] m_da = '0;

  always #10 clk = ~clk;

  ide_bus_glue i_ide_bus_glue (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .cpu_rw(cpu_rw), .cpu_addr(cpu_addr),
    .io_page_n(io_page_n), .ide_cs1_n(ide_cs1_n), .ide_cs3_n(ide_cs3_n),
    .hi_latch_n(hi_latch_n), .periph_en(periph_en), .ide_da(ide_da),
    .ide_ior_n(ide_ior_n), .ide_iow_n(ide_iow_n), .ide_rst_n(ide_rst_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d addr=%02h phi2=%0b rw=%0b io_n=%0b",
               req, act, exp, cpu_addr, phi2, cpu_rw, io_page_n);
    end
  endtask

  // One clk cycle: drive at negedge, check the gap before the edge, update model, check after.
  task automatic cyc(input logic ph, input logic rw, input logic io_n, input logic [7:0] a);
    int  slot;
    bit  win, e_cs1, e_cs3, e_hi, armed;
    @(negedge clk);
    phi2 = ph; cpu_rw = rw; io_page_n = io_n; cpu_addr = a;
    #5;
    if (rst_n && ph && !m_prev) begin
      chk("R11 read strobe before capture edge", ide_ior_n, 1);
      chk("R11 write strobe before capture edge", ide_iow_n, 1);
    end
    @(posedge clk);
    armed = rst_n && ph && m_prev == 1'b1 && ph;
    if (!rst_n) begin
      m_prev = 1'b1; m_da = '0; armed = 0;
    end else begin
      if (ph && !m_prev) m_da = a[2:0];
      m_prev = ph;
      armed = ph;
    end
    #5;
    win  = (io_n == 0) && (a >= 8'h80) && ((a / 16) % 2 == 1) && ((a / 8) % 2 == 0);
    slot = (a / 32) % 4;
    e_hi  = !(win && slot == 1);
    e_cs1 = !(win && slot == 2);
    e_cs3 = !(win && slot == 3);
    if (!win) begin
      chk("R1 cs1 outside window", ide_cs1_n, 1);
      chk("R1 cs3 outside window", ide_cs3_n, 1);
      chk("R1 hi latch outside window", hi_latch_n, 1);
      chk("R1 periph_en outside window", periph_en, 1);
    end else begin
      chk("R2 cs1 slot", ide_cs1_n, e_cs1);
      chk("R2 cs3 slot", ide_cs3_n, e_cs3);
      chk("R2 hi latch slot", hi_latch_n, e_hi);
    end
    chk("R3 periph_en", periph_en, (e_hi && e_cs1 && e_cs3) ? 1 : 0);
    chk("R4 bank exclusive", (!ide_cs1_n && !ide_cs3_n) ? 1 : 0, 0);
    chk("R5 ide_da", ide_da, m_da);
    chk("R6 write strobe", ide_iow_n, (armed && !rw && (!e_cs1 || !e_cs3)) ? 0 : 1);
    chk("R7 read strobe", ide_ior_n, (armed && rw && (!e_cs1 || !e_cs3)) ? 0 : 1);
    chk("R8 strobe exclusive", (!ide_ior_n && !ide_iow_n) ? 1 : 0, 0);
    if (!e_hi) chk("R9 hi latch quiet", {ide_ior_n, ide_iow_n, ide_cs1_n, ide_cs3_n}, 4'hF);
    chk("R10 drive reset", ide_rst_n, rst_n);
  endtask

  initial begin
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 8'hC5);
    chk("R10 da in reset", ide_da, 0);
    @(negedge clk); rst_n = 1'b1;
    cyc(1'b0, 1'b1, 1'b0, 8'h00);
    for (int io = 0; io < 2; io++)
      for (int rw = 0; rw < 2; rw++)
        for (int a = 0; a < 256; a++) begin
          cyc(1'b0, rw[0], io[0], a[7:0]);
          cyc(1'b1, rw[0], io[0], a[7:0]);
          cyc(1'b1, rw[0], io[0], a[7:0]);
          cyc(1'b0, rw[0], io[0], a[7:0]);
        end
    // R5: address changing while phi2 stays high is not followed
    cyc(1'b0, 1'b0, 1'b0, 8'hD5);
    cyc(1'b1, 1'b0, 1'b0, 8'hD5);
    cyc(1'b1, 1'b0, 1'b0, 8'hD2);
    chk("R5 hold during phase", ide_da, 5);
    cyc(1'b0, 1'b0, 1'b0, 8'hD2);
    // R11: reset released with phi2 already high loads nothing
    @(negedge clk); rst_n = 1'b0;
    cyc(1'b1, 1'b1, 1'b0, 8'hF7);
    cyc(1'b1, 1'b1, 1'b0, 8'hF7);
    @(negedge clk); rst_n = 1'b1;
    cyc(1'b1, 1'b1, 1'b0, 8'hF7);
    chk("R11 no load on running phase", ide_da, 0);
    cyc(1'b0, 1'b1, 1'b0, 8'hF7);
    cyc(1'b1, 1'b1, 1'b0, 8'hF7);
    chk("R11 load on fresh rise", ide_da, 7);
    cyc(1'b0, 1'b1, 1'b0, 8'hF7);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule